// File: doc/BRIEF.md
# Triggered Waveform Playback Sequencer

This block turns a local sample memory into a multichannel function generator. Each memory frame holds one sample word per channel. Once software has enabled memory playback and armed the unit, a trigger starts a run. The trigger is either a software command or a rising edge on an external pin. During the run, every tick of the update clock reads the next frame, one word per cycle, into shadow storage. It then moves the whole frame into the channel registers in a single cycle, so that every output changes together. The update clock is either a programmable divider of the system clock or the rising edges of an external clock pin.

A count register sets how many frames one pass plays. In single-shot mode the run stops after the last frame, sets a sticky done flag and may raise an interrupt. In continuous mode the frame counter wraps to zero and playback repeats, with no interrupt. It stops when the arm bit is cleared, or when the continuous bit is cleared, in which case the current pass ends as a single-shot run. The serial converter link and the host bus sit outside this block. The registers are written through simple write strobes.

Top module: `wave_seq`

## Requirements
- R1: After reset, csr_o, chan_o, mem_addr_o, upd_o and irq_o are all zero.
- R2: A trigger starts a run (busy, csr_o bit 8, goes to 1 on the edge that accepts it) only when memory enable (bit 0) and arm (bit 1) are both set and the count register is nonzero. Otherwise it is ignored.
- R3: Trigger select bit 5 = 0 takes a software trigger, which is a CSR write with bit 6 = 1. Bit 5 = 1 takes a rising edge of ext_trig_i after a two-flop synchroniser. The unselected source is ignored.
- R4: An update of frame f loads channel c with the memory word at address f*NUM_CH + c, with the frame in the upper bits and the channel in the low log2(NUM_CH) bits of mem_addr_o. All channels of chan_o change together in the cycle where upd_o is 1.
- R5: With the internal clock selected (bit 4 = 0), successive updates are exactly div+1 cycles apart, for div >= NUM_CH+1.
- R6: With bit 4 = 1, each synchronised rising edge of ext_clk_i causes one update, and the internal divider has no effect.
- R7: A pass plays frames 0 to N-1 in order, where N is the count register.
- R8: In single-shot mode (bit 2 = 0), on the cycle of the N-th update busy clears and done (bit 7) sets. irq_o equals done AND interrupt enable (bit 3). No further updates follow.
- R9: In continuous mode (bit 2 = 1), frame N-1 is followed by frame 0. Done stays 0 and irq_o stays 0.
- R10: Clearing arm during a run stops it on the next edge, with no further updates and done left at 0. Clearing the continuous bit during a run lets the current pass finish and then complete as in single-shot mode.
- R11: A trigger that arrives while a run is in progress has no effect: the frame sequence continues unchanged.
- R12: A CSR write with bit 7 = 1 clears done. A write with bit 7 = 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 8 | CSR write data (bit 6 software trigger, bit 7 clear done) |
| csr_o | output | 9 | CSR read value: control bits 5:0, done bit 7, busy bit 8 |
| cnt_wr_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | CNT_W | Number of frames per pass |
| div_wr_i | input | 1 | Divider register write strobe |
| div_wdata_i | input | DIV_W | Internal update period minus one, in cycles |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| ext_clk_i | input | 1 | Asynchronous external update clock |
| mem_addr_o | output | CNT_W+log2(NUM_CH) | Sample memory read address |
| mem_rdata_i | input | DATA_W | Sample memory read data, same cycle |
| chan_o | output | NUM_CH*DATA_W | Channel registers, channel c at bits c*DATA_W upward |
| upd_o | output | 1 | One-cycle pulse when chan_o takes a new frame |
| irq_o | output | 1 | Completion interrupt |

## Verification
The assertions assume that the count register is not rewritten while a run is in progress, because the frame bound check compares the playing frame against its current value. They also assume that mem_rdata_i is valid in the same cycle as mem_addr_o. The stimulus writes the count and divider registers only while the unit is idle, and it keeps the divider at or above NUM_CH+1. It models the memory as a combinational function of the address. The external pins are held for several cycles, so that every edge survives the synchroniser.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int CSR_WR_W = 8;
  localparam int CSR_RD_W = 9;
  localparam int B_CLKX  = 4;
  localparam int B_TRGX  = 5;
  localparam int B_SWTRG = 6;
  localparam int B_DONE  = 7;

  typedef struct packed {
    logic trig_ext;
    logic clk_ext;
    logic irq_en;
    logic cont;
    logic arm;
    logic mem_en;
  } ctl_t;
endpackage

// File: rtl/wseq_sync_edge.sv
module wseq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wseq_tick.sv
module wseq_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clk_ext_i,
  input  logic             ext_rise_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] dc_q;
  logic             wrap;

  assign wrap = (dc_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dc_q <= '0;
    else if (!run_i)  dc_q <= '0;
    else if (wrap)    dc_q <= '0;
    else              dc_q <= dc_q + 1'b1;
  end

  assign tick_o = run_i & (clk_ext_i ? ext_rise_i : wrap);
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl #(
  parameter int NUM_CH = 16,
  parameter int CNT_W  = 10,
  localparam int WORD_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              armed_i,
  input  logic              cont_i,
  input  logic              trig_i,
  input  logic              tick_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              busy_o,
  output logic              wr_o,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o,
  output logic              done_set_o,
  output logic [CNT_W+WORD_W-1:0] mem_addr_o
);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_CH - 1);

  logic              run_q, load_q, cmt_q;
  logic [CNT_W-1:0]  frame_q;
  logic [WORD_W-1:0] word_q;
  logic              last_frame, start;

  assign last_frame = (frame_q == cnt_i - 1'b1);
  assign start      = armed_i & ~run_q & trig_i & (cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      load_q  <= 1'b0;
      cmt_q   <= 1'b0;
      frame_q <= '0;
      word_q  <= '0;
    end else if (!armed_i) begin
      run_q  <= 1'b0;
      load_q <= 1'b0;
      cmt_q  <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      load_q  <= 1'b0;
      cmt_q   <= 1'b0;
      frame_q <= '0;
      word_q  <= '0;
    end else if (run_q) begin
      if (cmt_q) begin
        cmt_q <= 1'b0;
        if (!last_frame)  frame_q <= frame_q + 1'b1;
        else if (cont_i)  frame_q <= '0;
        else              run_q   <= 1'b0;
      end else if (load_q) begin
        word_q <= word_q + 1'b1;
        if (word_q == LAST_WORD) begin
          load_q <= 1'b0;
          cmt_q  <= 1'b1;
        end
      end else if (tick_i) begin
        load_q <= 1'b1;
        word_q <= '0;
      end
    end
  end

  assign busy_o     = run_q;
  assign wr_o       = run_q & load_q;
  assign word_o     = word_q;
  assign commit_o   = run_q & cmt_q;
  assign done_set_o = commit_o & last_frame & ~cont_i;
  assign mem_addr_o = {frame_q, word_q};
endmodule

// File: rtl/wseq_chregs.sv
module wseq_chregs #(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  localparam int WORD_W = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [WORD_W-1:0]        word_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic                     commit_i,
  output logic [NUM_CH*DATA_W-1:0] chan_o,
  output logic                     upd_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] shadow_q, out_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q <= '0;
        out_q    <= '0;
      end else begin
        if (wr_i && word_i == WORD_W'(c)) shadow_q <= data_i;
        if (commit_i)                     out_q    <= shadow_q;
      end
    end

    assign chan_o[c*DATA_W +: DATA_W] = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_o <= 1'b0;
    else         upd_o <= commit_i;
  end
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wseq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter int DIV_W  = 16,
  localparam int WORD_W = $clog2(NUM_CH),
  localparam int ADDR_W = CNT_W + WORD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csr_wr_i,
  input  logic [CSR_WR_W-1:0]      csr_wdata_i,
  output logic [CSR_RD_W-1:0]      csr_o,
  input  logic                     cnt_wr_i,
  input  logic [CNT_W-1:0]         cnt_wdata_i,
  input  logic                     div_wr_i,
  input  logic [DIV_W-1:0]         div_wdata_i,
  input  logic                     ext_trig_i,
  input  logic                     ext_clk_i,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [NUM_CH*DATA_W-1:0] chan_o,
  output logic                     upd_o,
  output logic                     irq_o
);
  ctl_t              ctl_q;
  logic              done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  div_q;
  logic              trig_rise, clk_rise, trig, tick;
  logic              busy, wr, commit, done_set;
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
    end else begin
      if (csr_wr_i) ctl_q <= ctl_t'(csr_wdata_i[B_TRGX:0]);
      if (done_set)                             done_q <= 1'b1;
      else if (csr_wr_i && csr_wdata_i[B_DONE]) done_q <= 1'b0;
      if (cnt_wr_i) cnt_q <= cnt_wdata_i;
      if (div_wr_i) div_q <= div_wdata_i;
    end
  end

  wseq_sync_edge #(.STAGES(2)) u_trig_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_trig_i), .rise_o(trig_rise)
  );
  wseq_sync_edge #(.STAGES(2)) u_clk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .rise_o(clk_rise)
  );

  assign trig = ctl_q.trig_ext ? trig_rise : (csr_wr_i & csr_wdata_i[B_SWTRG]);

  wseq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .clk_ext_i(ctl_q.clk_ext),
    .ext_rise_i(clk_rise), .div_i(div_q), .tick_o(tick)
  );

  wseq_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(ctl_q.mem_en & ctl_q.arm),
    .cont_i(ctl_q.cont), .trig_i(trig), .tick_i(tick), .cnt_i(cnt_q),
    .busy_o(busy), .wr_o(wr), .word_o(word), .commit_o(commit),
    .done_set_o(done_set), .mem_addr_o(mem_addr_o)
  );

  wseq_chregs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chregs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .word_i(word),
    .data_i(mem_rdata_i), .commit_i(commit), .chan_o(chan_o), .upd_o(upd_o)
  );

  assign csr_o = {busy, done_q, 1'b0, ctl_q};
  assign irq_o = done_q & ctl_q.irq_en;
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic             cont_i,
  input logic             arm_i,
  input logic             mem_en_i,
  input logic             upd_i,
  input logic [CNT_W-1:0] frame_i,
  input logic [CNT_W-1:0] cnt_i
);
  AST_START_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(arm_i && mem_en_i)); // R2

  AST_UPD_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> $past(busy_i)); // R4

  AST_UPD_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i); // R5

  AST_FRAME_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> frame_i < cnt_i); // R7

  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !busy_i && upd_i); // R8

  AST_LOOP_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !$past(cont_i)); // R9
endmodule

bind wave_seq wseq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(csr_o[8]), .done_i(csr_o[7]),
  .cont_i(csr_o[2]), .arm_i(csr_o[1]), .mem_en_i(csr_o[0]), .upd_i(upd_o),
  .frame_i(mem_addr_o[ADDR_W-1:WORD_W]), .cnt_i(cnt_q)
);

// File: tb/sim_wave_seq.sv
`timescale 1ns/1ps
module sim_wave_seq;
  localparam int NUM_CH = 16, DATA_W = 16, CNT_W = 10, DIV_W = 16;
  localparam int WORD_W = $clog2(NUM_CH), ADDR_W = CNT_W + WORD_W;
  localparam int VW = NUM_CH * DATA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wr = 1'b0, cnt_wr = 1'b0, div_wr = 1'b0;
  logic [7:0] csr_wd = '0;
  logic [CNT_W-1:0] cnt_wd = '0;
  logic [DIV_W-1:0] div_wd = '0;
  logic ext_trig = 1'b0, ext_clk = 1'b0;
  logic [8:0] csr;
  logic [ADDR_W-1:0] maddr;
  logic [DATA_W-1:0] mdata;
  logic [VW-1:0] chan;
  logic upd, irq;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] memw(input int a);
    return DATA_W'(a * 37 + 5);
  endfunction
  assign mdata = memw(int'(maddr));

  wave_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .csr_wr_i(csr_wr), .csr_wdata_i(csr_wd), .csr_o(csr),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd), .div_wr_i(div_wr), .div_wdata_i(div_wd),
    .ext_trig_i(ext_trig), .ext_clk_i(ext_clk), .mem_addr_o(maddr), .mem_rdata_i(mdata),
    .chan_o(chan), .upd_o(upd), .irq_o(irq)
  );

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div;
    logic             irq_en;
  } row_t;
  localparam row_t ROWS [3] = '{
    '{cnt: 10'd3, div: 16'd19, irq_en: 1'b1},
    '{cnt: 10'd1, div: 16'd17, irq_en: 1'b0},
    '{cnt: 10'd4, div: 16'd25, irq_en: 1'b1}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [7:0] v);
    csr_wr = 1'b1; csr_wd = v; step(); csr_wr = 1'b0; csr_wd = '0;
  endtask

  task automatic setup(input int c, input int d);
    cnt_wr = 1'b1; cnt_wd = CNT_W'(c); div_wr = 1'b1; div_wd = DIV_W'(d);
    step(); cnt_wr = 1'b0; div_wr = 1'b0;
  endtask

  task automatic wait_upd(input int lim, output int cyc);
    cyc = 0;
    do begin step(); cyc++; end while (!upd && cyc < lim);
  endtask

  function automatic logic [VW-1:0] frame_exp(input int f);
    logic [VW-1:0] v;
    for (int c = 0; c < NUM_CH; c++) v[c*DATA_W +: DATA_W] = memw(f * NUM_CH + c);
    return v;
  endfunction

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin step(); if (upd) seen++; end
    chk(tag, VW'(seen), '0);
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] ctl;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 csr", VW'(csr), '0);
    chk("R1 chan", chan, '0);
    chk("R1 addr/upd/irq", VW'({maddr, upd, irq}), '0);

    // table of single-shot runs
    foreach (ROWS[r]) begin
      setup(int'(ROWS[r].cnt), int'(ROWS[r].div));
      ctl = ROWS[r].irq_en ? 8'h0B : 8'h03;
      wr_csr(ctl);
      wr_csr(ctl | 8'h40);
      chk("R2 busy after trigger", VW'(csr[8]), VW'(1));
      for (int f = 0; f < int'(ROWS[r].cnt); f++) begin
        wait_upd(200, cyc);
        chk("R4 R7 frame data", chan, frame_exp(f));
        if (f > 0) chk("R5 update period", VW'(cyc), VW'(ROWS[r].div + 1));
      end
      chk("R8 busy/done", VW'(csr[8:7]), VW'(2'b01));
      chk("R8 irq", VW'(irq), VW'(ROWS[r].irq_en));
      quiet(3 * (int'(ROWS[r].div) + 1), "R8 no update after end");
      wr_csr(ctl);
      chk("R12 done kept on write 0", VW'(csr[7]), VW'(1));
      wr_csr(ctl | 8'h80);
      chk("R12 done cleared", VW'({csr[7], irq}), '0);
    end

    // R2: unarmed or zero count
    setup(2, 19);
    wr_csr(8'h02); wr_csr(8'h42);
    quiet(30, "R2 no run without memory enable");
    chk("R2 busy low no mem_en", VW'(csr[8]), '0);
    setup(0, 19);
    wr_csr(8'h03); wr_csr(8'h43);
    step();
    chk("R2 busy low zero count", VW'(csr[8]), '0);

    // R3 external trigger, R10 arm clear
    setup(4, 19);
    wr_csr(8'h23); wr_csr(8'h63);
    repeat (4) step();
    chk("R3 sw trigger ignored in ext mode", VW'(csr[8]), '0);
    ext_trig = 1'b1;
    cyc = 0;
    do begin step(); cyc++; end while (!csr[8] && cyc < 8);
    chk("R3 ext trigger starts run", VW'(csr[8]), VW'(1));
    ext_trig = 1'b0;
    wait_upd(200, cyc);
    chk("R3 first frame", chan, frame_exp(0));
    wr_csr(8'h21);
    step();
    chk("R10 arm clear stops", VW'(csr[8:7]), '0);
    quiet(60, "R10 no update after arm clear");
    chk("R10 chan holds", chan, frame_exp(0));

    // R11 retrigger ignored
    setup(3, 19);
    wr_csr(8'h03); wr_csr(8'h43);
    wait_upd(200, cyc);
    wr_csr(8'h43);
    wait_upd(200, cyc);
    chk("R11 retrigger ignored frame 1", chan, frame_exp(1));
    wait_upd(200, cyc);
    chk("R11 frame 2", chan, frame_exp(2));
    wr_csr(8'h83);

    // R6 external update clock
    setup(2, 65535);
    wr_csr(8'h13); wr_csr(8'h53);
    quiet(40, "R6 divider ignored");
    for (int f = 0; f < 2; f++) begin
      ext_clk = 1'b1; repeat (3) step(); ext_clk = 1'b0;
      wait_upd(40, cyc);
      chk("R6 ext clock frame", chan, frame_exp(f));
      repeat (3) step();
    end
    chk("R6 done after ext run", VW'(csr[8:7]), VW'(2'b01));
    wr_csr(8'h93);

    // R9 continuous, then R10 cont clear
    setup(2, 19);
    wr_csr(8'h0F); wr_csr(8'h4F);
    for (int k = 0; k < 5; k++) begin
      wait_upd(200, cyc);
      chk("R9 loop frame", chan, frame_exp(k % 2));
    end
    chk("R9 no done no irq", VW'({csr[8], csr[7], irq}), VW'(3'b100));
    wr_csr(8'h0B);
    wait_upd(200, cyc);
    chk("R10 pass finishes", chan, frame_exp(1));
    chk("R10 completes single-shot", VW'({csr[8], csr[7], irq}), VW'(3'b011));
    quiet(60, "R10 no update after completion");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule